// File: doc/BRIEF.md
# Multicycle Register-Memory Processor Core

This block is a compact 16-bit processor that repeatedly fetches, decodes and executes instructions held in one word-addressed memory of up to 1024 words. It keeps a program counter, an instruction register and four 16-bit working registers. Every instruction has one fixed format: an operation code, a working-register number and a memory word address. The four operations copy a memory word into a register, copy a register into memory, add a memory word to a register and subtract a memory word from a register.

Each instruction passes through a fixed series of steps. The core fetches the word at the program counter, increments the counter, decodes the word, reads the memory operand, computes the result, then writes it back to a register or to memory. Memory reads are synchronous. The word appears on the read bus one cycle after its address is presented, so the core spends a wait cycle before it captures it. The write strobe is raised only in the write-back cycle of a store.

Top module: `rm_core`

## Requirements
- R1: On reset the program counter loads the START_PC parameter (default 080H), all four working registers clear to zero and the core begins with an instruction fetch: while reset is held, mem_addr shows START_PC and mem_we is low.
- R2: The instruction fields are the opcode in bits 15:12, the working-register number in bits 11:10 (00 selects R0 through 11 selects R3) and the memory word address in bits 9:0. The four registers are independent of each other.
- R3: Opcode 0001 (load) copies the addressed memory word into the selected register.
- R4: Opcode 0010 (store) raises mem_we for exactly one cycle, with mem_addr equal to the address field and mem_wdata equal to the selected register. No working register changes.
- R5: Opcode 0011 (add) sets the register to register plus memory word, wrapping modulo 2^16 with no flag.
- R6: Opcode 0100 (subtract) sets the register to register minus memory word, wrapping modulo 2^16 with no flag.
- R7: Any other opcode is a no-operation. It takes 4 cycles, writes nothing and only advances the program counter.
- R8: Load, add and subtract take 8 cycles each and a store takes 5. The program counter advances by one per instruction, and mem_we is low in every cycle except the write-back cycle of a store.
- R9: Read data is taken from mem_rdata one cycle after its address is presented, both for the instruction word and for the operand.
- R10: With 1A01H, 3A02H and 2A00H at 080H to 082H and 0000H, 0009H and 0006H at 200H to 202H, the three instructions leave 000FH in word 200H, and the next fetch is from 083H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 10 | Memory word address |
| mem_wdata | output | 16 | Data for a memory write |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| mem_we | output | 1 | Memory write strobe |

## Verification
The bench aims at additions and subtractions that cross the signed boundary or wrap at zero and at all ones. A core that saturated, trapped or kept a seventeenth bit would store the wrong word. Undefined opcodes and the zero opcode are placed ahead of a store of a register that has never been written. A core that treated them as operations, or that did not clear its registers, would write early or write a nonzero value. Each store is timed to the exact cycle and the next fetch address is checked. A missing wait state, an extra step, a counter that advanced twice, or a strobe held too long or raised on a read therefore shows up as a shifted or extra write. Four loads into four different registers are stored back separately, which exposes any aliasing of the register-number field.

// File: rtl/rm_pkg.sv
package rm_pkg;
    localparam int OPW = 4;
    localparam int RSW = 2;

    localparam logic [OPW-1:0] OPC_LOAD  = 4'b0001;
    localparam logic [OPW-1:0] OPC_STORE = 4'b0010;
    localparam logic [OPW-1:0] OPC_ADD   = 4'b0011;
    localparam logic [OPW-1:0] OPC_SUB   = 4'b0100;

    typedef enum logic [2:0] {
        K_NOP, K_LOAD, K_STORE, K_ADD, K_SUB
    } kind_e;

    typedef enum logic [2:0] {
        S_FETCH, S_FWAIT, S_INCR, S_DECODE, S_OPRD, S_OWAIT, S_EXEC, S_WB
    } state_e;
endpackage

// File: rtl/rm_decode.sv
module rm_decode
    import rm_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 10
) (
    input  logic [DW-1:0]  ir,
    output kind_e          kind,
    output logic [RSW-1:0] rsel,
    output logic [AW-1:0]  maddr
);
    logic [OPW-1:0] opc;

    assign opc   = ir[DW-1 -: OPW];
    assign rsel  = ir[AW +: RSW];
    assign maddr = ir[AW-1:0];

    always_comb begin
        unique case (opc)
            OPC_LOAD:  kind = K_LOAD;
            OPC_STORE: kind = K_STORE;
            OPC_ADD:   kind = K_ADD;
            OPC_SUB:   kind = K_SUB;
            default:   kind = K_NOP;
        endcase
    end
endmodule

// File: rtl/rm_alu.sv
module rm_alu
    import rm_pkg::*;
#(
    parameter int DW = 16
) (
    input  kind_e         kind,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    always_comb begin
        unique case (kind)
            K_LOAD:  y = b;
            K_ADD:   y = a + b;
            K_SUB:   y = a - b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/rm_regfile.sv
module rm_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 4,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] rsel,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && wsel == SW'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    assign rdata = regs[rsel];
endmodule

// File: rtl/rm_core.sv
module rm_core
    import rm_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 10,
    parameter logic [AW-1:0] START_PC = 10'h080
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_we
);
    localparam int NREG = 1 << RSW;

    typedef struct packed {
        state_e        st;
        logic [AW-1:0] pc;
        logic [DW-1:0] ir;
        logic [DW-1:0] mdr;
        logic [DW-1:0] res;
    } core_t;

    core_t q, d;

    kind_e          kind;
    logic [RSW-1:0] rsel;
    logic [AW-1:0]  maddr;
    logic [DW-1:0]  rf_rdata;
    logic           rf_we;
    logic [DW-1:0]  alu_a, alu_b, alu_y;

    state_e         st_q;
    logic [AW-1:0]  pc_q;
    logic [DW-1:0]  ir_q;
    logic [DW-1:0]  res_q;

    assign st_q  = q.st;
    assign pc_q  = q.pc;
    assign ir_q  = q.ir;
    assign res_q = q.res;

    rm_decode #(.DW(DW), .AW(AW)) u_dec (
        .ir    (q.ir),
        .kind  (kind),
        .rsel  (rsel),
        .maddr (maddr)
    );

    rm_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wsel  (rsel),
        .wdata (q.res),
        .rsel  (rsel),
        .rdata (rf_rdata)
    );

    assign alu_a = rf_rdata;
    assign alu_b = q.mdr;

    rm_alu #(.DW(DW)) u_alu (
        .kind (kind),
        .a    (alu_a),
        .b    (alu_b),
        .y    (alu_y)
    );

    always_comb begin
        d     = q;
        rf_we = 1'b0;
        unique case (q.st)
            S_FETCH:  d.st = S_FWAIT;
            S_FWAIT: begin
                d.ir = mem_rdata;
                d.st = S_INCR;
            end
            S_INCR: begin
                d.pc = q.pc + AW'(1);
                d.st = S_DECODE;
            end
            S_DECODE: begin
                unique case (kind)
                    K_NOP:   d.st = S_FETCH;
                    K_STORE: d.st = S_WB;
                    default: d.st = S_OPRD;
                endcase
            end
            S_OPRD:   d.st = S_OWAIT;
            S_OWAIT: begin
                d.mdr = mem_rdata;
                d.st  = S_EXEC;
            end
            S_EXEC: begin
                d.res = alu_y;
                d.st  = S_WB;
            end
            S_WB: begin
                rf_we = (kind != K_STORE);
                d.st  = S_FETCH;
            end
            default:  d.st = S_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= S_FETCH;
            q.pc  <= START_PC;
            q.ir  <= '0;
            q.mdr <= '0;
            q.res <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_we    = (q.st == S_WB) && (kind == K_STORE);
    assign mem_wdata = rf_rdata;
    assign mem_addr  = (q.st == S_OPRD || q.st == S_OWAIT || q.st == S_WB) ? maddr : q.pc;
endmodule

// File: rtl/rm_core_chk.sv
module rm_core_chk
    import rm_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input state_e        st_q,
    input logic [AW-1:0] pc_q,
    input logic [DW-1:0] ir_q,
    input logic [DW-1:0] res_q,
    input logic [DW-1:0] mem_rdata,
    input logic          mem_we,
    input logic          rf_we,
    input kind_e         kind,
    input logic [DW-1:0] alu_a,
    input logic [DW-1:0] alu_b
);
    p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_no_dual_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && rf_we));

    p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_INCR) |=> (pc_q == $past(pc_q) + AW'(1)));

    p_pc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_INCR) |=> $stable(pc_q));

    p_ir_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_FWAIT) |=> (ir_q == $past(mem_rdata)));

    p_nop_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DECODE && kind == K_NOP) |=> (st_q == S_FETCH && !mem_we));

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXEC && kind == K_LOAD) |=> (res_q == $past(alu_b)));

    p_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXEC && kind == K_ADD) |=> (res_q == $past(alu_a) + $past(alu_b)));

    p_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_EXEC && kind == K_SUB) |=> (res_q == $past(alu_a) - $past(alu_b)));
endmodule

bind rm_core rm_core_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_q      (st_q),
    .pc_q      (pc_q),
    .ir_q      (ir_q),
    .res_q     (res_q),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .rf_we     (rf_we),
    .kind      (kind),
    .alu_a     (alu_a),
    .alu_b     (alu_b)
);

// File: tb/rm_core_tb.sv
`timescale 1ns/1ps
module rm_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_we;

    logic [15:0] mem [1024];

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int wrs = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rm_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // entry: {opcode, reg, first word, second word, expected stored word}
    localparam logic [53:0] VEC [7] = '{
        {4'h3, 2'd1, 16'h0009, 16'h0006, 16'h000F},
        {4'h3, 2'd3, 16'h7FFF, 16'h0001, 16'h8000},
        {4'h3, 2'd0, 16'hFFFF, 16'h0001, 16'h0000},
        {4'h4, 2'd2, 16'h0000, 16'h0001, 16'hFFFF},
        {4'h4, 2'd1, 16'h8000, 16'h0001, 16'h7FFF},
        {4'h4, 2'd3, 16'h0006, 16'h0009, 16'hFFFD},
        {4'h1, 2'd2, 16'h1111, 16'hABCD, 16'hABCD}
    };

    function automatic logic [15:0] enc(logic [3:0] op, logic [1:0] r, logic [9:0] a);
        return {op, r, a};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
        @(negedge clk);
    endtask

    task automatic release_reset();
        cyc = 0;
        wrs = 0;
        if (mem_we) wrs++;
        rst_n = 1'b1;
    endtask

    task automatic run_to(int target);
        while (cyc < target) begin
            @(negedge clk);
            cyc++;
            if (mem_we) wrs++;
        end
    endtask

    task automatic check_store(string tag, int at, logic [9:0] a, logic [15:0] v, int nwr);
        run_to(at);
        chk({tag, " we"}, 32'(mem_we), 32'd1);
        chk({tag, " addr"}, 32'(mem_addr), 32'(a));
        chk({tag, " data"}, 32'(mem_wdata), 32'(v));
        chk({tag, " write count"}, 32'(wrs), 32'(nwr));
    endtask

    initial begin
        #2000000;
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        // R1: reset state visible on the bus
        hold_reset();
        chk("R1 reset fetch address", 32'(mem_addr), 32'h080);
        chk("R1 reset write strobe", 32'(mem_we), 32'd0);

        // R10 / R9 / R3 / R5 / R4: the three-instruction program
        mem[10'h080] = 16'h1A01;
        mem[10'h081] = 16'h3A02;
        mem[10'h082] = 16'h2A00;
        mem[10'h200] = 16'h0000;
        mem[10'h201] = 16'h0009;
        mem[10'h202] = 16'h0006;
        release_reset();
        run_to(19);
        chk("R8 no write before store", 32'(wrs), 32'd0);
        check_store("R10 store", 20, 10'h200, 16'h000F, 1);
        run_to(21);
        chk("R8 next fetch address", 32'(mem_addr), 32'h083);
        chk("R4 strobe dropped", 32'(mem_we), 32'd0);
        chk("R10 memory word", 32'(mem[10'h200]), 32'h000F);

        // table of load/add/sub cases: load, operate, store
        for (int i = 0; i < 7; i++) begin
            logic [3:0]  op;
            logic [1:0]  r;
            logic [15:0] va, vb, ve;
            {op, r, va, vb, ve} = VEC[i];
            hold_reset();
            mem[10'h080] = enc(4'h1, r, 10'h300);
            mem[10'h081] = enc(op, r, 10'h301);
            mem[10'h082] = enc(4'h2, r, 10'h302);
            mem[10'h300] = va;
            mem[10'h301] = vb;
            release_reset();
            check_store($sformatf("R5 R6 R3 vector %0d", i), 20, 10'h302, ve, 1);
            run_to(21);
            chk($sformatf("R8 vector %0d next fetch", i), 32'(mem_addr), 32'h083);
        end

        // R7 undefined and zero opcodes, R1 registers cleared
        hold_reset();
        mem[10'h080] = 16'hF123;
        mem[10'h081] = 16'h0000;
        mem[10'h082] = enc(4'h2, 2'd3, 10'h310);
        mem[10'h310] = 16'h5555;
        release_reset();
        run_to(4);
        chk("R7 pc after first nop", 32'(mem_addr), 32'h081);
        check_store("R7 R1 store after nops", 12, 10'h310, 16'h0000, 1);
        run_to(13);
        chk("R7 next fetch", 32'(mem_addr), 32'h083);

        // R2 four independent registers
        hold_reset();
        for (int r = 0; r < 4; r++) begin
            mem[10'h080 + 10'(r)] = enc(4'h1, 2'(r), 10'h300 + 10'(r));
            mem[10'h084 + 10'(r)] = enc(4'h2, 2'(r), 10'h310 + 10'(r));
            mem[10'h300 + 10'(r)] = 16'h1111 * 16'(r + 1);
        end
        release_reset();
        for (int r = 0; r < 4; r++) begin
            check_store($sformatf("R2 register %0d", r), 36 + 5 * r,
                        10'h310 + 10'(r), 16'h1111 * 16'(r + 1), r + 1);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule